// File: doc/BRIEF.md
# Two-Wire Serial Slave with Downward-Stepping Register Pointer

This block lets an external two-wire (I2C) master reach a small register file. The system clock oversamples the bus lines and detects START, repeated START and STOP conditions. The block matches a 7-bit device address and acknowledges it. It then moves bytes between the bus and a plain register port: one address bus, one write strobe, write data and read data.

A write transfer first loads an internal register pointer, and the following bytes go to the register that pointer selects. A read transfer, which may come after a repeated START, streams registers starting at that pointer. The pointer steps down by one after each byte read, and it steps from 0x0C to 0x11 rather than to 0x0B.

The lowest device-address bit comes from a strap pin. One bit of a control register shuts the decoder off, so the two lines can carry another serial protocol. This block only drives SDA low through an output enable. It never stretches SCL.

Top module: `i2c_regfile_slave`

## Requirements
- R1: A START is an SDA fall while SCL is high. After it, the 7-bit address is compared with `{6'b001111, addr_sel}`, most significant bit first, and bit 0 of the byte is read(1)/write(0). On a match the slave asserts `sda_oe` throughout the ninth SCL clock.
- R2: The level on `addr_sel` picks the address. With `addr_sel`=1 the slave answers 0x1F and ignores 0x1E. With `addr_sel`=0 it answers 0x1E.
- R3: In a write transfer, the first byte after the address loads the pointer. Each later byte gives one cycle of `reg_we` with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte. Each byte is acknowledged in the same cycle as the strobe. A write does not move the pointer.
- R4: A read transfer returns `reg_rdata` at the current pointer, most significant bit first. A repeated START between the pointer write and the read is supported.
- R5: The pointer drops by one each time a read byte is loaded, even when only one byte is read. A later read with no new pointer starts at the lowered value.
- R6: When the pointer steps down from 0x0C it becomes 0x11.
- R7: After the master answers a read byte with NACK, `sda_oe` stays low until the next START.
- R8: A non-matching address is not acknowledged, and `sda_oe` stays low until the next START.
- R9: Bit 0 of register 0x20 is the disable bit, and it is 0 after reset. While it is 1, START conditions are ignored: there is no acknowledge and no register write.
- R10: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| addr_sel | input | 1 | Strap for device-address bit 0 |
| sda_oe | output | 1 | 1 pulls SDA low |
| reg_addr | output | 8 | Register pointer / access address |
| reg_we | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data |
| reg_rdata | input | 8 | Read data for `reg_addr`, combinational |

## Verification
Several rules are checked by the assertions on every cycle:
- SDA changes only while SCL is low.
- Each write strobe coincides with an acknowledge.
- The pointer steps down by one, or from 0x0C to 0x11, on each read load.
- The bus is silent after a rejected address or while the block is disabled.

Other behaviour shows only in the bench scenarios: the address decode, including the strap, and the pointer load from the first written byte. The same goes for the byte values that come back across a repeated START and over several reads, the end of a read on NACK, and the shut-off after the control write.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_ADDR, S_ACK, S_REG, S_WDAT, S_RDAT, S_MACK, S_IGN
    } phase_e;
endpackage

// File: rtl/i2c_rf_line_sync.sv
module i2c_rf_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_c,
    output logic stop_c
);
    logic [STAGES-1:0] scl_pipe_q, sda_pipe_q;
    logic              scl_prev_q, sda_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe_q <= '1;
            sda_pipe_q <= '1;
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_pipe_q <= {scl_pipe_q[STAGES-2:0], scl_in};
            sda_pipe_q <= {sda_pipe_q[STAGES-2:0], sda_in};
            scl_prev_q <= scl_pipe_q[STAGES-1];
            sda_prev_q <= sda_pipe_q[STAGES-1];
        end
    end

    assign scl_s    = scl_pipe_q[STAGES-1];
    assign sda_s    = sda_pipe_q[STAGES-1];
    assign scl_rise = scl_s & ~scl_prev_q;
    assign scl_fall = ~scl_s & scl_prev_q;
    // data line moves while the clock line stays high
    assign start_c  = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
    assign stop_c   = scl_s & scl_prev_q & ~sda_prev_q & sda_s;
endmodule

// File: rtl/i2c_rf_ptr_step.sv
module i2c_rf_ptr_step #(
    parameter int          AW        = 8,
    parameter logic [7:0]  JUMP_FROM = 8'h0C,
    parameter logic [7:0]  JUMP_TO   = 8'h11
) (
    input  logic [AW-1:0] ptr,
    output logic [AW-1:0] ptr_nx
);
    always_comb begin
        if (ptr == AW'(JUMP_FROM)) ptr_nx = AW'(JUMP_TO);
        else                       ptr_nx = ptr - AW'(1);
    end
endmodule

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave #(
    parameter int          DW        = 8,
    parameter int          AW        = 8,
    parameter int          SYNC      = 2,
    parameter logic [5:0]  ADDR_HI   = 6'b001111,
    parameter logic [7:0]  CTRL_ADDR = 8'h20,
    parameter int          DIS_BIT   = 0,
    parameter logic [7:0]  JUMP_FROM = 8'h0C,
    parameter logic [7:0]  JUMP_TO   = 8'h11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_in,
    input  logic          sda_in,
    input  logic          addr_sel,
    output logic          sda_oe,
    output logic [AW-1:0] reg_addr,
    output logic          reg_we,
    output logic [DW-1:0] reg_wdata,
    input  logic [DW-1:0] reg_rdata
);
    import i2c_rf_pkg::*;

    localparam int CW = $clog2(DW);

    typedef struct packed {
        phase_e        st;
        phase_e        nxt;
        logic [CW-1:0] cnt;
        logic [DW-1:0] sh;
        logic          done;
        logic          mack;
        logic          oe;
        logic [AW-1:0] ptr;
        logic          we;
        logic [DW-1:0] wdata;
        logic          dis;
    } core_t;

    core_t q, d;

    logic scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;
    logic [AW-1:0] ptr_nx;
    logic ptr_dec;
    logic ign_w, idle_w;
    logic [6:0] dev_addr;

    i2c_rf_line_sync #(.STAGES(SYNC)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_c(start_c), .stop_c(stop_c)
    );

    i2c_rf_ptr_step #(.AW(AW), .JUMP_FROM(JUMP_FROM), .JUMP_TO(JUMP_TO)) u_step (
        .ptr(q.ptr), .ptr_nx(ptr_nx)
    );

    assign dev_addr = {ADDR_HI, addr_sel};

    always_comb begin
        d       = q;
        d.we    = 1'b0;
        ptr_dec = 1'b0;
        if (stop_c) begin
            d.st = S_IDLE;
            d.oe = 1'b0;
        end else if (start_c && !q.dis) begin
            d.st   = S_ADDR;
            d.cnt  = '0;
            d.done = 1'b0;
            d.oe   = 1'b0;
        end else begin
            case (q.st)
                S_ADDR, S_REG, S_WDAT: begin
                    if (scl_rise) begin
                        d.sh  = {q.sh[DW-2:0], sda_s};
                        d.cnt = q.cnt + CW'(1);
                        if (q.cnt == CW'(DW-1)) d.done = 1'b1;
                    end else if (scl_fall && q.done) begin
                        d.done = 1'b0;
                        d.oe   = 1'b1;
                        d.st   = S_ACK;
                        if (q.st == S_ADDR) begin
                            if (q.sh[DW-1:1] == dev_addr) begin
                                d.nxt = q.sh[0] ? S_RDAT : S_REG;
                            end else begin
                                d.oe = 1'b0;
                                d.st = S_IGN;
                            end
                        end else if (q.st == S_REG) begin
                            d.ptr = AW'(q.sh);
                            d.nxt = S_WDAT;
                        end else begin
                            d.we    = 1'b1;
                            d.wdata = q.sh;
                            d.nxt   = S_WDAT;
                            if (q.ptr == AW'(CTRL_ADDR)) d.dis = q.sh[DIS_BIT];
                        end
                    end
                end
                S_ACK: begin
                    if (scl_fall) begin
                        d.oe  = 1'b0;
                        d.cnt = '0;
                        d.st  = q.nxt;
                        if (q.nxt == S_RDAT) begin
                            d.sh    = reg_rdata;
                            d.oe    = ~reg_rdata[DW-1];
                            d.ptr   = ptr_nx;
                            ptr_dec = 1'b1;
                        end
                    end
                end
                S_RDAT: begin
                    if (scl_fall) begin
                        if (q.cnt == CW'(DW-1)) begin
                            d.oe  = 1'b0;
                            d.cnt = '0;
                            d.st  = S_MACK;
                        end else begin
                            d.sh  = {q.sh[DW-2:0], 1'b0};
                            d.oe  = ~q.sh[DW-2];
                            d.cnt = q.cnt + CW'(1);
                        end
                    end
                end
                S_MACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        if (q.mack) begin
                            d.st    = S_RDAT;
                            d.sh    = reg_rdata;
                            d.oe    = ~reg_rdata[DW-1];
                            d.ptr   = ptr_nx;
                            ptr_dec = 1'b1;
                        end else begin
                            d.st = S_IGN;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= S_IDLE;
            q.nxt   <= S_IDLE;
            q.cnt   <= '0;
            q.sh    <= '0;
            q.done  <= 1'b0;
            q.mack  <= 1'b0;
            q.oe    <= 1'b0;
            q.ptr   <= '0;
            q.we    <= 1'b0;
            q.wdata <= '0;
            q.dis   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign ign_w     = (q.st == S_IGN);
    assign idle_w    = (q.st == S_IDLE);
    assign sda_oe    = q.oe;
    assign reg_addr  = q.ptr;
    assign reg_we    = q.we;
    assign reg_wdata = q.wdata;
endmodule

// File: rtl/i2c_rf_checker.sv
module i2c_rf_checker #(
    parameter int         AW        = 8,
    parameter logic [7:0] JUMP_FROM = 8'h0C,
    parameter logic [7:0] JUMP_TO   = 8'h11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_in,
    input logic          sda_oe,
    input logic          reg_we,
    input logic [AW-1:0] reg_addr,
    input logic          ptr_dec,
    input logic          ign_w,
    input logic          idle_w,
    input logic          dis
);
    a_r10_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_in);

    a_r3_write_acked: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> sda_oe);

    a_r5_ptr_down: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_dec && reg_addr != AW'(JUMP_FROM)) |=> reg_addr == $past(reg_addr) - AW'(1));

    a_r6_ptr_jump: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_dec && reg_addr == AW'(JUMP_FROM)) |=> reg_addr == AW'(JUMP_TO));

    a_r8_silent_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        ign_w |-> !sda_oe);

    a_r9_silent_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (dis && idle_w) |-> !sda_oe);
endmodule

bind i2c_regfile_slave i2c_rf_checker #(.AW(AW), .JUMP_FROM(JUMP_FROM), .JUMP_TO(JUMP_TO)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_oe(sda_oe), .reg_we(reg_we),
    .reg_addr(reg_addr), .ptr_dec(ptr_dec), .ign_w(ign_w), .idle_w(idle_w), .dis(q.dis)
);

// File: tb/i2c_regfile_slave_test.sv
module i2c_regfile_slave_test;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic addr_sel = 1'b0;
    logic sda_oe, reg_we;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic sda_line;
    logic [7:0] mem [256];
    logic [15:0] exp_wr [$];
    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    assign sda_line  = sda_m & ~sda_oe;
    assign reg_rdata = mem[reg_addr];

    i2c_regfile_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line), .addr_sel(addr_sel),
        .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl = 1'b0; wq(Q);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; wq(Q);
        scl = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q);
        scl = 1'b1; wq(Q);
        sda_m = 1'b1; wq(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(Q);
            scl = 1'b1; wq(2*Q);
            scl = 1'b0; wq(Q);
        end
        sda_m = 1'b1; wq(Q);
        scl = 1'b1; wq(Q);
        ack = ~sda_line; wq(Q);
        scl = 1'b0; wq(Q);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(Q);
            scl = 1'b1; wq(Q);
            b[i] = sda_line; wq(Q);
            scl = 1'b0; wq(Q);
        end
        sda_m = ~give_ack; wq(Q);
        scl = 1'b1; wq(2*Q);
        scl = 1'b0; wq(Q);
        sda_m = 1'b1;
    endtask

    // driver helper: write bytes and queue the expected strobes
    task automatic do_write(input logic [7:0] dev, input logic [7:0] ptr,
                            input logic [7:0] d0, input int nbytes, input string req);
        logic ack;
        bus_start();
        send_byte(dev, ack);   check({req, " address ack"}, ack, 1'b1);
        send_byte(ptr, ack);   check({req, " pointer ack"}, ack, 1'b1);
        for (int k = 0; k < nbytes; k++) begin
            exp_wr.push_back({ptr, d0 + 8'(k)});
            send_byte(d0 + 8'(k), ack); check({req, " data ack"}, ack, 1'b1);
        end
        bus_stop();
    endtask

    function automatic logic [7:0] initval(input int a);
        return 8'(a) ^ 8'h5A;
    endfunction

    // monitor: models the register file and pops expected writes
    initial begin
        for (int i = 0; i < 256; i++) mem[i] = initval(i);
        forever begin
            @(negedge clk);
            if (reg_we) begin
                if (exp_wr.size() == 0) begin
                    check("R3/R9 unexpected write", {reg_addr, reg_wdata}, 16'h0);
                end else begin
                    check("R3 write addr/data", {reg_addr, reg_wdata}, exp_wr.pop_front());
                end
                mem[reg_addr] = reg_wdata;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [7:0] b;
        int bad;
        wq(5);
        rst_n = 1'b1;
        wq(5);
        check("R1 reset sda_oe", sda_oe, 1'b0);
        check("R3 reset reg_we", reg_we, 1'b0);

        // R1 R3: pointer 0x05, two bytes, pointer stays put
        do_write(8'h3C, 8'h05, 8'h3C, 2, "R3");
        check("R3 pointer unchanged by write", reg_addr, 8'h05);

        // R4 R5: repeated start read of two bytes
        bus_start();
        send_byte(8'h3C, ack); check("R1 addr ack", ack, 1'b1);
        send_byte(8'h05, ack); check("R4 ptr ack", ack, 1'b1);
        bus_rstart();
        send_byte(8'h3D, ack); check("R4 read addr ack", ack, 1'b1);
        recv_byte(1'b1, b); check("R4 first byte", b, 8'h3D);
        recv_byte(1'b0, b); check("R5 second byte", b, initval(4));
        bad = 0;
        for (int i = 0; i < 4*Q; i++) begin @(negedge clk); if (sda_oe) bad++; end
        check("R7 released after NACK", bad, 0);
        bus_stop();

        // R5: single byte read, pointer continues downward
        bus_start();
        send_byte(8'h3D, ack);
        recv_byte(1'b0, b); check("R5 read continues at 0x03", b, initval(3));
        bus_stop();
        check("R5 pointer after single read", reg_addr, 8'h02);

        // R6: jump from 0x0C to 0x11
        bus_start();
        send_byte(8'h3C, ack);
        send_byte(8'h0D, ack);
        bus_rstart();
        send_byte(8'h3D, ack);
        recv_byte(1'b1, b); check("R6 byte at 0x0D", b, initval(13));
        recv_byte(1'b1, b); check("R6 byte at 0x0C", b, initval(12));
        recv_byte(1'b0, b); check("R6 byte at 0x11", b, initval(17));
        bus_stop();

        // R8: foreign address
        bus_start();
        send_byte(8'h40, ack); check("R8 foreign addr nack", ack, 1'b0);
        send_byte(8'h00, ack); check("R8 no ack afterwards", ack, 1'b0);
        bus_stop();

        // R2: strap high
        addr_sel = 1'b1;
        bus_start();
        send_byte(8'h3C, ack); check("R2 0x1E rejected", ack, 1'b0);
        bus_stop();
        bus_start();
        send_byte(8'h3F, ack); check("R2 0x1F read ack", ack, 1'b1);
        recv_byte(1'b0, b); check("R2 read via 0x1F", b, initval(16));
        bus_stop();

        // R9: set disable bit, then nothing answers
        do_write(8'h3E, 8'h20, 8'h01, 1, "R9");
        bus_start();
        send_byte(8'h3E, ack); check("R9 disabled no ack", ack, 1'b0);
        send_byte(8'h07, ack); check("R9 disabled no ptr ack", ack, 1'b0);
        send_byte(8'hAA, ack); check("R9 disabled no data ack", ack, 1'b0);
        bus_stop();
        wq(10);
        check("R3 all expected writes seen", exp_wr.size(), 0);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule